// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small data cache placed between a single-word processor port and a slow memory that moves one whole line per transfer. It stores 32 words as 8 lines of 4 words, organised as 4 sets of 2 ways. Each line keeps a tag, a valid bit and a dirty bit, and each set keeps one least-recently-used bit. Writes are allocated on a miss and written back only when a dirty line is evicted.

On the processor side, a read that hits returns its word in the same cycle with no stall. A write that hits also finishes in that cycle and marks the line dirty. `cpu_stall` is the processor port's back-pressure. While it is high, the processor must hold `cpu_rd`, `cpu_wr`, `cpu_addr` and `cpu_wdata` unchanged. The access completes on the first rising edge at which `cpu_stall` is low.

On the memory side, the cache raises one request (`line_rd` or `line_wr`) and holds it, with a stable address, until a one-cycle `line_ack` pulse arrives. A miss whose victim is dirty first writes that line back and only then fetches the new line. A write miss is handled as a fetch followed by a write hit, all inside one unbroken stall period.

Top module: `cache_2way_wb`

## Requirements
- R1: A read whose line is resident shows the addressed word on `cpu_rdata` in the same cycle, with `cpu_stall` low.
- R2: A write whose line is resident completes with no stall and changes only the addressed word. Word k of a line sits in bits 32k+31..32k of the 128-bit line data.
- R3: A read miss raises `cpu_stall` before the next rising edge. It then fetches the line with `line_rd` at line address `cpu_addr[29:2]` and returns the word from that line once the stall drops.
- R4: A write miss raises the stall once for one contiguous period. When the stall drops, the fetched line holds the written word, and every other word keeps its value from memory.
- R5: The set index is `cpu_addr[3:2]`, the low 2 bits of the line address. Two lines that map to the same set can both be resident.
- R6: On a miss, the victim is an invalid way if either way is invalid, otherwise the least recently used way. Hits and fills both make their way the most recently used.
- R7: A dirty victim is written back before the fetch. `line_wr` is held with line address {victim tag, set} and the victim's data until `line_ack`, and only after that is `line_rd` raised.
- R8: A clean or invalid victim is never written back: a miss on such a line causes exactly one fetch and no write.
- R9: After reset all lines are invalid and `line_rd`, `line_wr` and `cpu_stall` are low while no access is requested. The first access to any line is a miss.
- R10: `line_rd` and `line_wr` are never high together. Each memory request stays asserted until its `line_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | Read request, held while stalled |
| cpu_wr | input | 1 | Write request, held while stalled |
| cpu_addr | input | 30 | Word address |
| cpu_wdata | input | 32 | Word to write |
| cpu_rdata | output | 32 | Read word, valid in the cycle stall is low |
| cpu_stall | output | 1 | Back-pressure: processor must hold its request |
| line_rd | output | 1 | Line fetch request |
| line_wr | output | 1 | Line write-back request |
| line_addr | output | 28 | Line address of the current request |
| line_wdata | output | 128 | Line being written back |
| line_rdata | input | 128 | Fetched line, valid with line_ack |
| line_ack | input | 1 | One-cycle completion pulse |

## Verification
Two functions can land in one miss: evicting a dirty victim and fetching the new line. The bench provokes this by dirtying a line and then touching two other lines of the same set, so that the dirty line becomes least recently used. It then judges that the write-back completes before the fetch, that it goes to the victim's line address, and that it carries the line as the processor last wrote it. Sweeps over 16 lines and a long pseudo-random mix check every read against a word-level reference, and every hit, miss and eviction against a small replacement model.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_FLUSH = 2'd1,
    CS_FETCH = 2'd2
  } cstate_e;

  // after touching a way, the other way becomes the replacement candidate
  function automatic logic lru_after(input logic way);
    return ~way;
  endfunction

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store
  import cache_pkg::*;
#(
  parameter int TAG_W = 26,
  parameter int SETS  = 4,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic             hit_way,
  output logic             vict_way,
  output logic             vict_dirty,
  output logic [TAG_W-1:0] vict_tag,
  input  logic [SET_W-1:0] upd_set,
  input  logic             touch_en,
  input  logic             touch_way,
  input  logic             dirty_en,
  input  logic             fill_en,
  input  logic             fill_way,
  input  logic [TAG_W-1:0] fill_tag
);

  logic [1:0]       match;
  logic [1:0]       vld_rd;
  logic [1:0]       dty_rd;
  logic [TAG_W-1:0] tag_rd [2];
  logic [SETS-1:0]  lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  dty_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= '0;
        dty_q <= '0;
      end else if (fill_en && (fill_way == 1'(w))) begin
        tag_q[upd_set] <= fill_tag;
        vld_q[upd_set] <= 1'b1;
        dty_q[upd_set] <= 1'b0;
      end else if (dirty_en && (touch_way == 1'(w))) begin
        dty_q[upd_set] <= 1'b1;
      end
    end

    assign vld_rd[w] = vld_q[lk_set];
    assign dty_rd[w] = dty_q[lk_set];
    assign tag_rd[w] = tag_q[lk_set];
    assign match[w]  = vld_q[lk_set] && (tag_q[lk_set] == lk_tag);

    // R3
    fill_valid_chk: assert property (@(posedge clk) disable iff (rst)
      (fill_en && fill_way == 1'(w)) |=> (vld_q[$past(upd_set)] && !dty_q[$past(upd_set)]));
  end

  assign hit     = |match;
  assign hit_way = match[1];

  always_comb begin
    if (!vld_rd[0])      vict_way = 1'b0;
    else if (!vld_rd[1]) vict_way = 1'b1;
    else                 vict_way = lru_q[lk_set];
  end

  assign vict_dirty = vld_rd[vict_way] && dty_rd[vict_way];
  assign vict_tag   = tag_rd[vict_way];

  always_ff @(posedge clk) begin
    if (rst) begin
      lru_q <= '0;
    end else if (fill_en) begin
      lru_q[upd_set] <= lru_after(fill_way);
    end else if (touch_en) begin
      lru_q[upd_set] <= lru_after(touch_way);
    end
  end

  // R6
  vict_invalid_first_chk: assert property (@(posedge clk) disable iff (rst)
    !(vld_rd[0] && vld_rd[1]) |-> !vld_rd[vict_way]);

  // R5
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    !(match[0] && match[1]));

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int WORD_W = 32,
  parameter int WPL    = 4,
  parameter int SETS   = 4,
  localparam int SET_W  = $clog2(SETS),
  localparam int OFF_W  = $clog2(WPL),
  localparam int LINE_W = WORD_W * WPL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SET_W-1:0]  rd_set,
  input  logic              rd_way,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [WORD_W-1:0] rd_word,
  input  logic [SET_W-1:0]  wb_set,
  input  logic              wb_way,
  output logic [LINE_W-1:0] wb_line,
  input  logic [SET_W-1:0]  wr_set,
  input  logic              word_we,
  input  logic              word_way,
  input  logic [OFF_W-1:0]  word_off,
  input  logic [WORD_W-1:0] word_data,
  input  logic              line_we,
  input  logic              line_way,
  input  logic [LINE_W-1:0] line_data
);

  logic [LINE_W-1:0] rd_line [2];
  logic [LINE_W-1:0] wb_rd   [2];
  logic [WORD_W-1:0] lanes   [WPL];

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [LINE_W-1:0] line_q [SETS];

    for (genvar k = 0; k < WPL; k++) begin : g_lane
      always_ff @(posedge clk) begin
        if (line_we && (line_way == 1'(w))) begin
          line_q[wr_set][k*WORD_W +: WORD_W] <= line_data[k*WORD_W +: WORD_W];
        end else if (word_we && (word_way == 1'(w)) && (word_off == OFF_W'(k))) begin
          line_q[wr_set][k*WORD_W +: WORD_W] <= word_data;
        end
      end
    end

    assign rd_line[w] = line_q[rd_set];
    assign wb_rd[w]   = line_q[wb_set];

    // R3
    fill_store_chk: assert property (@(posedge clk) disable iff (rst)
      (line_we && line_way == 1'(w)) |=> (line_q[$past(wr_set)] == $past(line_data)));
  end

  for (genvar k = 0; k < WPL; k++) begin : g_pick
    assign lanes[k] = rd_line[rd_way][k*WORD_W +: WORD_W];
  end

  assign rd_word = lanes[rd_off];
  assign wb_line = wb_rd[wb_way];

  // R2
  one_writer_chk: assert property (@(posedge clk) disable iff (rst)
    !(line_we && word_we));

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_rd,
  input  logic req_wr,
  input  logic hit,
  input  logic vict_dirty,
  input  logic line_ack,
  output logic idle,
  output logic stall,
  output logic line_rd,
  output logic line_wr,
  output logic capture,
  output logic fill_en,
  output logic acc_ok
);

  cstate_e state_q, state_d;
  logic    req;

  assign req = req_rd || req_wr;

  always_comb begin
    state_d = state_q;
    stall   = 1'b0;
    line_rd = 1'b0;
    line_wr = 1'b0;
    capture = 1'b0;
    fill_en = 1'b0;
    acc_ok  = 1'b0;
    unique case (state_q)
      CS_IDLE: begin
        if (req && hit) begin
          acc_ok = 1'b1;
        end else if (req) begin
          stall   = 1'b1;
          capture = 1'b1;
          state_d = vict_dirty ? CS_FLUSH : CS_FETCH;
        end
      end
      CS_FLUSH: begin
        stall   = 1'b1;
        line_wr = 1'b1;
        if (line_ack) state_d = CS_FETCH;
      end
      CS_FETCH: begin
        stall   = 1'b1;
        line_rd = 1'b1;
        if (line_ack) begin
          fill_en = 1'b1;
          state_d = CS_IDLE;
        end
      end
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= CS_IDLE;
    else     state_q <= state_d;
  end

  assign idle = (state_q == CS_IDLE);

  // R10
  no_dual_req_chk: assert property (@(posedge clk) disable iff (rst)
    !(line_rd && line_wr));

  // R10
  fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (line_rd && !line_ack) |=> line_rd);

  // R10
  flush_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (line_wr && !line_ack) |=> line_wr);

  // R7
  flush_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (line_wr && line_ack) |=> line_rd);

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!line_rd && !line_wr));

  // R3
  mem_busy_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (line_rd || line_wr) |-> stall);

endmodule

// File: rtl/cache_2way_wb.sv
module cache_2way_wb
  import cache_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int WORD_W = 32,
  parameter int WPL    = 4,
  parameter int SETS   = 4,
  localparam int OFF_W   = $clog2(WPL),
  localparam int SET_W   = $clog2(SETS),
  localparam int LADDR_W = ADDR_W - OFF_W,
  localparam int TAG_W   = LADDR_W - SET_W,
  localparam int LINE_W  = WORD_W * WPL
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [WORD_W-1:0]  cpu_wdata,
  output logic [WORD_W-1:0]  cpu_rdata,
  output logic               cpu_stall,
  output logic               line_rd,
  output logic               line_wr,
  output logic [LADDR_W-1:0] line_addr,
  output logic [LINE_W-1:0]  line_wdata,
  input  logic [LINE_W-1:0]  line_rdata,
  input  logic               line_ack
);

  logic [OFF_W-1:0]   cpu_off;
  logic [SET_W-1:0]   cpu_set;
  logic [TAG_W-1:0]   cpu_tag;
  logic               hit, hit_way, vict_way, vict_dirty;
  logic [TAG_W-1:0]   vict_tag;
  logic               idle, capture, fill_en, acc_ok;
  logic [LADDR_W-1:0] miss_laddr_q;
  logic               vict_way_q;
  logic [TAG_W-1:0]   vict_tag_q;
  logic [SET_W-1:0]   miss_set;
  logic [SET_W-1:0]   upd_set;

  assign cpu_off  = cpu_addr[OFF_W-1:0];
  assign cpu_set  = cpu_addr[OFF_W +: SET_W];
  assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign miss_set = miss_laddr_q[SET_W-1:0];
  assign upd_set  = fill_en ? miss_set : cpu_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      miss_laddr_q <= '0;
      vict_way_q   <= 1'b0;
      vict_tag_q   <= '0;
    end else if (capture) begin
      miss_laddr_q <= cpu_addr[ADDR_W-1:OFF_W];
      vict_way_q   <= vict_way;
      vict_tag_q   <= vict_tag;
    end
  end

  cache_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_rd     (cpu_rd),
    .req_wr     (cpu_wr),
    .hit        (hit),
    .vict_dirty (vict_dirty),
    .line_ack   (line_ack),
    .idle       (idle),
    .stall      (cpu_stall),
    .line_rd    (line_rd),
    .line_wr    (line_wr),
    .capture    (capture),
    .fill_en    (fill_en),
    .acc_ok     (acc_ok)
  );

  cache_tag_store #(.TAG_W(TAG_W), .SETS(SETS)) u_tags (
    .clk        (clk),
    .rst        (rst),
    .lk_set     (cpu_set),
    .lk_tag     (cpu_tag),
    .hit        (hit),
    .hit_way    (hit_way),
    .vict_way   (vict_way),
    .vict_dirty (vict_dirty),
    .vict_tag   (vict_tag),
    .upd_set    (upd_set),
    .touch_en   (acc_ok),
    .touch_way  (hit_way),
    .dirty_en   (acc_ok && cpu_wr),
    .fill_en    (fill_en),
    .fill_way   (vict_way_q),
    .fill_tag   (miss_laddr_q[LADDR_W-1:SET_W])
  );

  cache_data_store #(.WORD_W(WORD_W), .WPL(WPL), .SETS(SETS)) u_data (
    .clk       (clk),
    .rst       (rst),
    .rd_set    (cpu_set),
    .rd_way    (hit_way),
    .rd_off    (cpu_off),
    .rd_word   (cpu_rdata),
    .wb_set    (miss_set),
    .wb_way    (vict_way_q),
    .wb_line   (line_wdata),
    .wr_set    (upd_set),
    .word_we   (acc_ok && cpu_wr),
    .word_way  (hit_way),
    .word_off  (cpu_off),
    .word_data (cpu_wdata),
    .line_we   (fill_en),
    .line_way  (vict_way_q),
    .line_data (line_rdata)
  );

  assign line_addr = line_wr ? {vict_tag_q, miss_set} : miss_laddr_q;

  // R1
  rd_hit_nostall_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && cpu_rd && hit) |-> !cpu_stall);

  // R3
  miss_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && (cpu_rd || cpu_wr) && !hit) |-> cpu_stall);

  // R3
  fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
    line_rd |-> (line_addr == miss_laddr_q));

  // R10
  addr_steady_chk: assert property (@(posedge clk) disable iff (rst)
    ((line_rd || line_wr) && !line_ack) |=> $stable(line_addr));

endmodule

// File: tb/sim_cache_2way_wb.sv
module sim_cache_2way_wb;

  localparam int LAT   = 3;
  localparam int NLINE = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [29:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_stall;
  logic         line_rd, line_wr;
  logic [27:0]  line_addr;
  logic [127:0] line_wdata;
  logic [127:0] line_rdata = '0;
  logic         line_ack = 1'b0;

  always #2 clk = ~clk;

  cache_2way_wb u0 (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .line_rd(line_rd), .line_wr(line_wr), .line_addr(line_addr),
    .line_wdata(line_wdata), .line_rdata(line_rdata), .line_ack(line_ack)
  );

  int nchk = 0, nfail = 0, cyc = 0;

  // memory model and event log
  logic [127:0] mem [NLINE];
  int           acnt = 0;
  int           wb_cnt = 0, fill_cnt = 0, wb_at = 0, fill_at = 0;
  logic [27:0]  wb_line_seen;
  logic [127:0] wb_data_seen;

  function automatic logic [31:0] init_word(input int w);
    return {16'hC0DE ^ 16'(w >> 2), 16'(w * 7 + 3)};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (line_ack) begin
      line_ack <= 1'b0;
      acnt     <= 0;
      if (line_wr) begin
        mem[line_addr[5:0]] <= line_wdata;
        wb_cnt       <= wb_cnt + 1;
        wb_at        <= cyc;
        wb_line_seen <= line_addr;
        wb_data_seen <= line_wdata;
      end else if (line_rd) begin
        fill_cnt <= fill_cnt + 1;
        fill_at  <= cyc;
      end
    end else if (line_rd ^ line_wr) begin
      if (acnt == LAT) begin
        line_ack <= 1'b1;
        if (line_rd) line_rdata <= mem[line_addr[5:0]];
      end else begin
        acnt <= acnt + 1;
      end
    end
  end

  // word-level reference and replacement model
  logic [31:0] gold [NLINE*4];
  int          m_tag [2][4];
  logic        m_vld [2][4];
  logic        m_dty [2][4];
  logic        m_lru [4];

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic access(input logic rd, input int waddr, input logic [31:0] wd,
                        output logic was_miss);
    int   line, set, tag, way, n, wb0, fl0;
    logic p_hit, p_wb;
    int   p_wb_line;
    logic [127:0] gl;
    line = waddr >> 2; set = line % 4; tag = line >> 2;
    p_hit = 1'b0; way = 0;
    for (int w = 0; w < 2; w++)
      if (m_vld[w][set] && m_tag[w][set] == tag) begin p_hit = 1'b1; way = w; end
    p_wb = 1'b0; p_wb_line = 0;
    if (!p_hit) begin
      if (!m_vld[0][set]) way = 0;
      else if (!m_vld[1][set]) way = 1;
      else way = int'(m_lru[set]);
      p_wb = m_vld[way][set] && m_dty[way][set];
      p_wb_line = m_tag[way][set] * 4 + set;
    end
    gl = '0;
    if (p_wb)
      for (int k = 0; k < 4; k++) gl[k*32 +: 32] = gold[p_wb_line*4 + k];
    wb0 = wb_cnt; fl0 = fill_cnt;

    @(negedge clk);
    cpu_rd = rd; cpu_wr = !rd; cpu_addr = 30'(waddr); cpu_wdata = wd;
    #1;
    was_miss = cpu_stall;
    // R1 R2: hits never stall; R3 R4: misses stall in the request cycle
    chk(was_miss == !p_hit, rd ? "R3 read miss/hit stall" : "R4 write miss/hit stall",
        128'(was_miss), 128'(!p_hit));
    n = 0;
    while (cpu_stall && n < 400) begin @(negedge clk); #1; n++; end
    if (rd) chk(cpu_rdata == gold[waddr], "R1 R3 read data", 128'(cpu_rdata), 128'(gold[waddr]));
    @(posedge clk); #1;
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    // R7 R8: write-back count, target, contents and order
    chk((wb_cnt - wb0) == int'(p_wb), "R7 R8 write-back count", 128'(wb_cnt - wb0), 128'(p_wb));
    chk((fill_cnt - fl0) == int'(!p_hit), "R3 fetch count", 128'(fill_cnt - fl0), 128'(!p_hit));
    if (p_wb) begin
      chk(wb_line_seen == 28'(p_wb_line), "R7 write-back line address",
          128'(wb_line_seen), 128'(p_wb_line));
      chk(wb_data_seen == gl, "R2 R7 write-back data lanes", wb_data_seen, gl);
      chk(wb_at < fill_at, "R7 write-back before fetch", 128'(wb_at), 128'(fill_at));
    end
    // model update
    if (!p_hit) begin
      m_vld[way][set] = 1'b1; m_dty[way][set] = 1'b0; m_tag[way][set] = tag;
    end
    m_lru[set] = (way == 0);
    if (!rd) begin
      m_dty[way][set] = 1'b1;
      gold[waddr] = wd;
    end
  endtask

  logic        mflag;
  logic [15:0] lfsr;

  initial begin
    for (int l = 0; l < NLINE; l++)
      for (int k = 0; k < 4; k++) begin
        mem[l][k*32 +: 32] = init_word(l*4 + k);
        gold[l*4 + k] = init_word(l*4 + k);
      end
    for (int s = 0; s < 4; s++) begin
      m_lru[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin
        m_vld[w][s] = 1'b0; m_dty[w][s] = 1'b0; m_tag[w][s] = 0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R9: quiet after reset
    chk(!cpu_stall, "R9 idle stall", 128'(cpu_stall), 128'(0));
    chk(!line_rd && !line_wr, "R9 idle memory requests", 128'({line_rd, line_wr}), 128'(0));
    @(negedge clk); #1;
    chk(!cpu_stall && !line_rd && !line_wr, "R9 idle second cycle",
        128'({cpu_stall, line_rd, line_wr}), 128'(0));

    // set 0: lines 0, 4, 8, 12 (word addresses 0, 16, 32, 48)
    access(1, 0, 0, mflag);  chk(mflag, "R9 first access misses", 128'(mflag), 128'(1));
    access(1, 17, 0, mflag); chk(mflag, "R6 invalid way taken", 128'(mflag), 128'(1));
    access(1, 2, 0, mflag);  chk(!mflag, "R5 both lines of set resident", 128'(mflag), 128'(0));
    access(1, 33, 0, mflag); chk(mflag, "R6 third line misses", 128'(mflag), 128'(1));
    access(1, 3, 0, mflag);  chk(!mflag, "R6 recently used line kept", 128'(mflag), 128'(0));
    access(1, 18, 0, mflag); chk(mflag, "R6 least recently used evicted", 128'(mflag), 128'(1));
    access(0, 1, 32'h1111_2222, mflag); chk(!mflag, "R2 write hit no stall", 128'(mflag), 128'(0));
    access(1, 1, 0, mflag);  chk(!mflag, "R2 written word read back", 128'(mflag), 128'(0));
    access(1, 0, 0, mflag);  chk(!mflag, "R2 neighbour word untouched", 128'(mflag), 128'(0));
    access(1, 34, 0, mflag); chk(mflag, "R8 clean victim miss", 128'(mflag), 128'(1));
    access(1, 19, 0, mflag); chk(mflag, "R7 dirty victim evicted", 128'(mflag), 128'(1));
    access(0, 50, 32'hCAFE_0050, mflag); chk(mflag, "R4 write miss", 128'(mflag), 128'(1));
    access(1, 50, 0, mflag); chk(!mflag, "R4 written word after fill", 128'(mflag), 128'(0));
    access(1, 48, 0, mflag); chk(!mflag, "R4 other word from memory", 128'(mflag), 128'(0));

    // sweep: read all, write all, read all over 16 lines
    for (int a = 0; a < 64; a++) access(1, a, 0, mflag);
    for (int a = 0; a < 64; a++) access(0, a, 32'h5A00_0000 + 32'(a * 32'h0101), mflag);
    for (int a = 0; a < 64; a++) access(1, a, 0, mflag);

    // pseudo-random mix over 64 lines
    lfsr = 16'hACE1;
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(lfsr[0], int'(lfsr[15:8]), {lfsr, ~lfsr}, mflag);
    end
    summary();
  end

endmodule